// File: doc/BRIEF.md
# Immediate Prefix Merge Unit

This unit sits in the decode stage of a 32-bit processor pipeline. It watches the accepted instruction stream and builds the 32-bit immediate operand for each instruction that carries a 16-bit immediate field. Normally that field is sign-extended. A dedicated prefix instruction can instead supply the upper 16 bits. The prefix parks its 16-bit payload in a one-shot holding register. If the very next accepted instruction is immediate-form, its operand becomes the parked half joined with its own field, with no sign extension.

The main decoder tells the unit which words are immediate-form. From the moment a prefix is accepted until its successor is accepted, the unit raises an interrupt-inhibit flag, so an interrupt cannot fall between the two halves of the pair. A pipeline flush drops any pending prefix, so a payload from an abandoned path never reaches an instruction on the new path.

Top module: `imm_merge_unit`

## Requirements
- R1: While `rst_n` is low, and immediately after it is asserted (asynchronously), `irq_inhibit` and `imm_wide` are 0 and `imm_out` is 0. Any pending prefix is dropped.
- R2: An accepted immediate-form word with no pending prefix yields `imm_out` = sign extension of word bits [15:0] to 32 bits, with `imm_wide` = 0.
- R3: An accepted immediate-form word with a pending prefix yields `imm_out` = {held payload, word bits [15:0]}, with no sign extension and `imm_wide` = 1.
- R4: A word is a prefix when its bits [31:26] equal 6'b101100; its payload is bits [15:0]. A prefix takes precedence even if `in_is_imm` is high. An accepted prefix leaves `imm_out` unchanged and clears `imm_wide`. Any other opcode value, including 6'b101101, is not a prefix.
- R5: A pending prefix is consumed by the next accepted word. If that word is not immediate-form, the payload is discarded: `imm_out` holds, and a later immediate-form word is sign-extended.
- R6: `irq_inhibit` is 1 from the cycle after a prefix is accepted until the cycle after the next non-prefix word is accepted, when it returns to 0.
- R7: A prefix accepted while a prefix is pending replaces the held payload and keeps the lock (and `irq_inhibit`) active for one more instruction.
- R8: In a cycle with `in_valid` low and `flush` low, `imm_out`, `imm_wide`, `irq_inhibit` and the pending payload do not change.
- R9: `flush` high drops the pending prefix and clears `irq_inhibit` and `imm_wide` on the next edge. A word offered in the same cycle is ignored and `imm_out` holds.
- R10: `imm_out` and `imm_wide` are registered. They change at the first clock edge after the word is accepted, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Instruction word accepted this cycle |
| in_word | input | 32 | Instruction word |
| in_is_imm | input | 1 | Decoder marks the word as immediate-form |
| flush | input | 1 | Pipeline redirect; drops pending prefix |
| imm_out | output | 32 | Immediate operand of the last accepted immediate-form word |
| imm_wide | output | 1 | Last accepted word used a prefix payload |
| irq_inhibit | output | 1 | Prefix pending; interrupts must be held off |

## Verification
The hardest states to reach from the ports are those where a lock is pending and something other than a clean consumer arrives. These are a stall, a second prefix, a non-immediate word, a flush with a valid word in the same cycle, and an asynchronous reset. The stimulus table sets up a prefix and then applies each of these interruptions in turn. After each one it follows with an immediate word with bit 15 set, so the result shows whether the old payload leaked or was correctly dropped. Directed tests then cover reset in the middle of a lock and the one-cycle output latency.

// File: rtl/imm_merge_pkg.sv
package imm_merge_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int OPC_W  = 6;
  localparam logic [OPC_W-1:0] OPC_PREFIX = 6'b101100;

  typedef struct packed {
    logic              pending;
    logic [HALF_W-1:0] payload;
  } lock_t;
endpackage

// File: rtl/imm_prefix_detect.sv
module imm_prefix_detect
  import imm_merge_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int OW  = OPC_W,
  parameter logic [OW-1:0] OPC = OPC_PREFIX
) (
  input  logic [W-1:0] word,
  output logic         is_prefix
);
  always_comb begin
    is_prefix = (word[W-1 -: OW] == OPC);
  end
endmodule

// File: rtl/imm_lock_reg.sv
module imm_lock_reg
  import imm_merge_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          flush,
  input  logic          is_prefix,
  input  logic [HW-1:0] new_payload,
  output logic          pending,
  output logic [HW-1:0] payload
);
  logic          pend_d;
  logic [HW-1:0] pay_d;
  logic          pay_en;

  always_comb begin
    pend_d = pending;
    pay_en = 1'b0;
    pay_d  = new_payload;
    if (flush) begin
      pend_d = 1'b0;
    end else if (accept) begin
      pend_d = is_prefix;
      pay_en = is_prefix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else begin
      pending <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      payload <= '0;
    end else if (pay_en) begin
      payload <= pay_d;
    end
  end
endmodule

// File: rtl/imm_operand_build.sv
module imm_operand_build
  import imm_merge_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          flush,
  input  logic          is_prefix,
  input  logic          is_imm,
  input  logic [HW-1:0] field,
  input  logic          pending,
  input  logic [HW-1:0] payload,
  output logic [W-1:0]  imm_out,
  output logic          imm_wide
);
  localparam int EXT_W = W - HW;

  logic          consume;
  logic [W-1:0]  imm_d;
  logic          wide_d;
  logic          imm_en;
  logic          wide_en;

  always_comb begin
    consume = accept && !flush && is_imm && !is_prefix;
    imm_en  = consume;
    wide_en = flush || accept;
    if (pending) begin
      imm_d = {{(EXT_W-HW){1'b0}}, payload, field};
    end else begin
      imm_d = {{EXT_W{field[HW-1]}}, field};
    end
    wide_d = consume && pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_out <= '0;
    end else if (imm_en) begin
      imm_out <= imm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_wide <= 1'b0;
    end else if (wide_en) begin
      imm_wide <= wide_d;
    end
  end
endmodule

// File: rtl/imm_merge_unit.sv
module imm_merge_unit
  import imm_merge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_is_imm,
  input  logic              flush,
  output logic [WORD_W-1:0] imm_out,
  output logic              imm_wide,
  output logic              irq_inhibit
);
  logic              is_prefix;
  logic              pending;
  logic [HALF_W-1:0] payload;

  imm_prefix_detect #(.W(WORD_W), .OW(OPC_W), .OPC(OPC_PREFIX)) u_det (
    .word      (in_word),
    .is_prefix (is_prefix)
  );

  imm_lock_reg #(.HW(HALF_W)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (in_valid),
    .flush       (flush),
    .is_prefix   (is_prefix),
    .new_payload (in_word[HALF_W-1:0]),
    .pending     (pending),
    .payload     (payload)
  );

  imm_operand_build #(.W(WORD_W), .HW(HALF_W)) u_build (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (in_valid),
    .flush     (flush),
    .is_prefix (is_prefix),
    .is_imm    (in_is_imm),
    .field     (in_word[HALF_W-1:0]),
    .pending   (pending),
    .payload   (payload),
    .imm_out   (imm_out),
    .imm_wide  (imm_wide)
  );

  assign irq_inhibit = pending;
endmodule

// File: rtl/imm_merge_chk.sv
module imm_merge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        in_is_imm,
  input logic        flush,
  input logic [31:0] imm_out,
  input logic        imm_wide,
  input logic        irq_inhibit
);
  logic pfx;
  assign pfx = (in_word[31:26] == 6'b101100);

  a_r6_inhibit_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flush && pfx |=> irq_inhibit);

  a_r6_inhibit_release: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flush && !pfx |=> !irq_inhibit);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !flush |=> $stable(irq_inhibit) && $stable(imm_out) && $stable(imm_wide));

  a_r9_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !irq_inhibit && !imm_wide && $stable(imm_out));

  a_r3_widened: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flush && in_is_imm && !pfx && irq_inhibit |=> imm_wide);

  a_r2_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flush && in_is_imm && !pfx && !irq_inhibit |=>
      !imm_wide && (imm_out == {{16{$past(in_word[15])}}, $past(in_word[15:0])}));
endmodule

bind imm_merge_unit imm_merge_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_word     (in_word),
  .in_is_imm   (in_is_imm),
  .flush       (flush),
  .imm_out     (imm_out),
  .imm_wide    (imm_wide),
  .irq_inhibit (irq_inhibit)
);

// File: tb/imm_merge_unit_test.sv
module imm_merge_unit_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        in_is_imm;
  logic        flush;
  logic [31:0] imm_out;
  logic        imm_wide;
  logic        irq_inhibit;

  int n_chk;
  int n_bad;

  imm_merge_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_is_imm(in_is_imm), .flush(flush), .imm_out(imm_out),
    .imm_wide(imm_wide), .irq_inhibit(irq_inhibit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {valid, flush, is_imm, word, exp_out, exp_wide, exp_inhibit}
  localparam int NV = 19;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,32'h0000_8001,32'hFFFF_8001,1'b0,1'b0}, // R2 negative
    {1'b1,1'b0,1'b1,32'h0000_1234,32'h0000_1234,1'b0,1'b0}, // R2 positive
    {1'b1,1'b0,1'b0,32'hB000_ABCD,32'h0000_1234,1'b0,1'b1}, // R6 prefix sets inhibit
    {1'b0,1'b0,1'b1,32'h0000_0000,32'h0000_1234,1'b0,1'b1}, // R8 stall
    {1'b1,1'b0,1'b1,32'h0000_8001,32'hABCD_8001,1'b1,1'b0}, // R3 widened
    {1'b1,1'b0,1'b1,32'h0000_8001,32'hFFFF_8001,1'b0,1'b0}, // R5 one-shot
    {1'b1,1'b0,1'b0,32'hB000_1111,32'hFFFF_8001,1'b0,1'b1}, // R7 first prefix
    {1'b1,1'b0,1'b0,32'hB000_2222,32'hFFFF_8001,1'b0,1'b1}, // R7 second prefix
    {1'b1,1'b0,1'b1,32'h0000_0042,32'h2222_0042,1'b1,1'b0}, // R7 replaced payload
    {1'b1,1'b0,1'b0,32'hB000_7777,32'h2222_0042,1'b0,1'b1}, // R4 prefix clears wide
    {1'b1,1'b0,1'b0,32'h1234_5678,32'h2222_0042,1'b0,1'b0}, // R5 discard
    {1'b1,1'b0,1'b1,32'h0000_8003,32'hFFFF_8003,1'b0,1'b0}, // R5 no leak
    {1'b1,1'b0,1'b0,32'hB000_5555,32'hFFFF_8003,1'b0,1'b1}, // R9 setup
    {1'b1,1'b1,1'b1,32'h0000_0009,32'hFFFF_8003,1'b0,1'b0}, // R9 flush drops word
    {1'b1,1'b0,1'b1,32'h0000_FFFF,32'hFFFF_FFFF,1'b0,1'b0}, // R9 no leak after flush
    {1'b1,1'b0,1'b1,32'hB000_0001,32'hFFFF_FFFF,1'b0,1'b1}, // R4 prefix beats is_imm
    {1'b1,1'b0,1'b1,32'hC000_0005,32'h0001_0005,1'b1,1'b0}, // R3 consumer
    {1'b1,1'b0,1'b0,32'hB400_0009,32'h0001_0005,1'b0,1'b0}, // R4 opcode 101101 not prefix
    {1'b1,1'b0,1'b1,32'h0000_8010,32'hFFFF_8010,1'b0,1'b0}  // R4 no lock from 101101
  };

  task automatic check(input string req, input logic [31:0] eo,
                       input logic ew, input logic ei);
    n_chk++;
    if (imm_out !== eo || imm_wide !== ew || irq_inhibit !== ei) begin
      n_bad++;
      $display("FAIL %s: out=%h wide=%b inh=%b expected out=%h wide=%b inh=%b",
               req, imm_out, imm_wide, irq_inhibit, eo, ew, ei);
    end
  endtask

  task automatic drive(input logic v, input logic f, input logic i, input logic [31:0] w);
    in_valid = v; flush = f; in_is_imm = i; in_word = w;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][68], VEC[k][67], VEC[k][66], VEC[k][65:34]);
      @(negedge clk);
      check($sformatf("vector %0d", k), VEC[k][33:2], VEC[k][1], VEC[k][0]);
    end
    drive(1'b0, 1'b0, 1'b0, 32'h0);
    @(negedge clk);

    // R10: output holds before the edge, updates after it
    drive(1'b1, 1'b0, 1'b1, 32'h0000_0077);
    #2;
    check("R10 before edge", 32'hFFFF_8010, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 after edge", 32'h0000_0077, 1'b0, 1'b0);

    // R1: asynchronous reset while a prefix is pending
    drive(1'b1, 1'b0, 1'b0, 32'hB000_9999);
    @(negedge clk);
    check("R6 pending before reset", 32'h0000_0077, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 32'h0);
    #3 rst_n = 1'b0;
    #2;
    check("R1 async reset", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 32'h0000_0005);
    @(negedge clk);
    check("R1 lock dropped by reset", 32'h0000_0005, 1'b0, 1'b0);

    // R8: long stall keeps a pending prefix
    drive(1'b1, 1'b0, 1'b0, 32'hB000_4321);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 32'h0000_0001);
    repeat (5) @(negedge clk);
    check("R8 long stall", 32'h0000_0005, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b1, 32'h0000_F000);
    @(negedge clk);
    check("R3 after stall", 32'h4321_F000, 1'b1, 1'b0);

    drive(1'b0, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule